// File: doc/BRIEF.md
# Chip-Select External Bus Cycle Generator

This block sits between one internal request port and an external parallel bus that serves several chip-select regions. An internal master presents an address, a size code (1, 2 or 4 bytes), a direction and write data. The block finds the region the address falls in and turns the request into one or more external beats, with the chip select, a read or write strobe, the beat address, a 2-bit transfer-size code and the write data placed in the low byte lanes. When the access is finished it pulses a done flag and returns the assembled read data, or an error flag if no region matched.

Each region has its own static settings: a base address, a span given as log2 of its size in bytes, a port width of 8, 16 or 32 bits, a recovery count of 0 to 3 idle cycles after reads, a separate count of 0 to 3 idle cycles after writes, and a burst enable. A request wider than the region's port becomes several consecutive narrow beats. With burst on, these beats come back to back under one continuous chip select. With burst off, one idle cycle separates them. The block handles one access at a time. Requests are expected to be naturally aligned to their size.

Top module: `csbus_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_done`, `rsp_err`, every `ext_cs` bit, `ext_rd` and `ext_wr` are 0.
- R2: Region i matches when address and base agree in every bit at or above position `span`. When several regions match, the lowest index wins. At most one `ext_cs` bit is ever high.
- R3: A request that matches no region drives no chip select and no strobe. `rsp_done` and `rsp_err` are both high in the first cycle after acceptance, and `rsp_rdata` is 0.
- R4: Port code 0, 1 and 2 gives a port of 1, 2 and 4 bytes. Size code 0, 1 and 2 requests 1, 2 and 4 bytes. Each beat carries min(size, port) bytes, and the beat count is size divided by beat bytes.
- R5: Beat k uses address `req_addr + k*beat_bytes`. The beats are little-endian: a write beat carries request bytes `k*beat_bytes` upward on the low lanes of `ext_wdata`, and every lane above the beat width is 0.
- R6: A read returns on `rsp_rdata` the low `beat_bytes` lanes of `ext_rdata` from each beat, placed at byte offset `k*beat_bytes`. All bytes above the request size are 0.
- R7: `ext_tsiz` is 2'b01 for a 1-byte beat, 2'b10 for a 2-byte beat and 2'b00 for a 4-byte beat.
- R8: When burst is enabled and there is more than one beat, the beats occupy consecutive cycles and `ext_burst` is high during them. When burst is disabled, one cycle with no chip select separates the beats and `ext_burst` stays 0.
- R9: After the last beat of a read, the region's read recovery count N (0 to 3) adds N cycles with no chip select before `rsp_done`.
- R10: After the last beat of a write, the region's write recovery count N (0 to 3) adds N cycles with no chip select before `rsp_done`.
- R11: Request acceptance to `rsp_done` takes beats + gaps + recovery + 1 cycles. `req_ready` is 0 from acceptance until the cycle after the one-cycle `rsp_done` pulse.
- R12: `ext_rd` is high exactly in read beats and `ext_wr` exactly in write beats. The two are never high together, and neither is high without a chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is accepted when valid and ready are both high at a clock edge |
| req_addr | input | ADDR_W | Byte address of the request |
| req_size | input | 2 | Size code: 0=1 byte, 1=2 bytes, 2=4 bytes |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data, little-endian |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read data, valid with rsp_done |
| rsp_err | output | 1 | No region matched, valid with rsp_done |
| cfg_base | input | NUM_CS*ADDR_W | Per-region base address |
| cfg_span | input | NUM_CS*SPAN_W | Per-region log2 of region size |
| cfg_port | input | NUM_CS*2 | Per-region port width code |
| cfg_dead | input | NUM_CS*2 | Per-region idle cycles after a read |
| cfg_hold | input | NUM_CS*2 | Per-region idle cycles after a write |
| cfg_burst | input | NUM_CS | Per-region burst enable |
| ext_cs | output | NUM_CS | Active-high chip selects |
| ext_addr | output | ADDR_W | Beat address |
| ext_tsiz | output | 2 | Beat transfer-size code |
| ext_rd | output | 1 | Read strobe |
| ext_wr | output | 1 | Write strobe |
| ext_burst | output | 1 | Burst beat marker |
| ext_wdata | output | 32 | Write beat data on the low lanes |
| ext_rdata | input | 32 | Read data from the device |

## Verification
Reads and writes of every size are issued to regions with 8-, 16- and 32-bit ports. Single-beat, two-beat and four-beat cases therefore show whether the address steps, the lane order and the tsiz code are right. The same multi-beat request is sent once to a burst region and once to a non-burst region, and the measured latency tells back-to-back beats apart from beats separated by a gap. Recovery counts of 0 to 3 on both directions show whether read and write idle cycles are picked from the correct field. An address inside two overlapping regions checks the decode priority, and unmapped reads and writes check the error path.

// File: rtl/csbus_pkg.sv
package csbus_pkg;

    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BEAT,
        ST_GAP,
        ST_RECOV,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [1:0] port;
        logic [1:0] dead;
        logic [1:0] hold;
        logic       burst;
    } cs_cfg_t;

    // log2 of a byte count from a 2-bit code, code 3 treated as 4 bytes
    function automatic logic [1:0] code_log2(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic logic [1:0] tsiz_of(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return 2'b01;
            3'd2:    return 2'b10;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] lane_mask(input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return 32'h0000_00FF;
            3'd2:    return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

endpackage

// File: rtl/csbus_decode.sv
module csbus_decode #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32,
    parameter int SPAN_W = 5,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NUM_CS*ADDR_W-1:0] cfg_base,
    input  logic [NUM_CS*SPAN_W-1:0] cfg_span,
    output logic                     hit,
    output logic [IDX_W-1:0]         sel_idx
);

    logic [NUM_CS-1:0] match;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_region
        logic [ADDR_W-1:0] base_g;
        logic [SPAN_W-1:0] span_g;
        logic [ADDR_W-1:0] keep_g;
        assign base_g   = cfg_base[g*ADDR_W +: ADDR_W];
        assign span_g   = cfg_span[g*SPAN_W +: SPAN_W];
        assign keep_g   = {ADDR_W{1'b1}} << span_g;
        assign match[g] = ((addr ^ base_g) & keep_g) == '0;
    end

    // lowest index has priority
    always_comb begin
        sel_idx = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) sel_idx = IDX_W'(i);
        end
    end

    assign hit = |match;

endmodule

// File: rtl/csbus_plan.sv
module csbus_plan
    import csbus_pkg::*;
(
    input  logic [1:0] size_code,
    input  logic [1:0] port_code,
    output logic [2:0] beat_bytes,
    output logic [2:0] beat_count,
    output logic [1:0] beat_tsiz
);

    logic [1:0] size_lg;
    logic [1:0] port_lg;
    logic [1:0] beat_lg;

    always_comb begin
        size_lg    = code_log2(size_code);
        port_lg    = code_log2(port_code);
        beat_lg    = (size_lg < port_lg) ? size_lg : port_lg;
        beat_bytes = 3'd1 << beat_lg;
        beat_count = 3'd1 << (size_lg - beat_lg);
        beat_tsiz  = tsiz_of(beat_bytes);
    end

endmodule

// File: rtl/csbus_seq.sv
module csbus_seq
    import csbus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              dec_hit,
    input  logic [IDX_W-1:0]  dec_idx,
    input  logic [1:0]        sel_dead,
    input  logic [1:0]        sel_hold,
    input  logic              sel_burst,
    input  logic [2:0]        plan_bytes,
    input  logic [2:0]        plan_count,
    input  logic [1:0]        plan_tsiz,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_err,
    output logic [NUM_CS-1:0] ext_cs,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [1:0]        ext_tsiz,
    output logic              ext_rd,
    output logic              ext_wr,
    output logic              ext_burst,
    output logic [DATA_W-1:0] ext_wdata,
    input  logic [DATA_W-1:0] ext_rdata
);

    seq_state_e        st_q;
    logic [IDX_W-1:0]  idx_q;
    logic [1:0]        dead_q, hold_q;
    logic              burst_q, multi_q, we_q, err_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [2:0]        bytes_q, left_q;
    logic [1:0]        tsiz_q, off_q, cnt_q;

    logic              in_beat;
    logic [DATA_W-1:0] beat_mask;
    logic [4:0]        shamt;
    logic [1:0]        recov;

    assign in_beat   = (st_q == ST_BEAT);
    assign beat_mask = lane_mask(bytes_q);
    assign shamt     = {off_q, 3'b000};
    assign recov     = we_q ? hold_q : dead_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            idx_q   <= '0;
            dead_q  <= '0;
            hold_q  <= '0;
            burst_q <= 1'b0;
            multi_q <= 1'b0;
            we_q    <= 1'b0;
            err_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            bytes_q <= 3'd1;
            left_q  <= '0;
            tsiz_q  <= '0;
            off_q   <= '0;
            cnt_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_q   <= dec_idx;
                        dead_q  <= sel_dead;
                        hold_q  <= sel_hold;
                        burst_q <= sel_burst;
                        multi_q <= (plan_count != 3'd1);
                        we_q    <= req_write;
                        err_q   <= !dec_hit;
                        addr_q  <= req_addr;
                        wdata_q <= req_wdata;
                        rdata_q <= '0;
                        bytes_q <= plan_bytes;
                        left_q  <= plan_count - 3'd1;
                        tsiz_q  <= plan_tsiz;
                        off_q   <= '0;
                        st_q    <= dec_hit ? ST_BEAT : ST_DONE;
                    end
                end
                ST_BEAT: begin
                    if (!we_q) begin
                        rdata_q <= rdata_q | ((ext_rdata & beat_mask) << shamt);
                    end
                    if (left_q == 3'd0) begin
                        if (recov != 2'd0) begin
                            cnt_q <= recov;
                            st_q  <= ST_RECOV;
                        end else begin
                            st_q  <= ST_DONE;
                        end
                    end else begin
                        addr_q <= addr_q + ADDR_W'(bytes_q);
                        off_q  <= off_q + bytes_q[1:0];
                        left_q <= left_q - 3'd1;
                        st_q   <= burst_q ? ST_BEAT : ST_GAP;
                    end
                end
                ST_GAP: begin
                    st_q <= ST_BEAT;
                end
                ST_RECOV: begin
                    cnt_q <= cnt_q - 2'd1;
                    if (cnt_q == 2'd1) st_q <= ST_DONE;
                end
                ST_DONE: begin
                    st_q <= ST_IDLE;
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign ext_cs[g] = in_beat && (idx_q == IDX_W'(g));
    end

    assign ext_rd    = in_beat && !we_q;
    assign ext_wr    = in_beat && we_q;
    assign ext_addr  = in_beat ? addr_q : '0;
    assign ext_tsiz  = in_beat ? tsiz_q : 2'b00;
    assign ext_burst = in_beat && burst_q && multi_q;
    assign ext_wdata = (in_beat && we_q) ? ((wdata_q >> shamt) & beat_mask) : '0;

    assign req_ready = (st_q == ST_IDLE);
    assign rsp_done  = (st_q == ST_DONE);
    assign rsp_err   = rsp_done && err_q;
    assign rsp_rdata = rsp_done ? rdata_q : '0;

endmodule

// File: rtl/csbus_ctrl.sv
module csbus_ctrl
    import csbus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32,
    parameter int SPAN_W = 5
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     rsp_err,
    input  logic [NUM_CS*ADDR_W-1:0] cfg_base,
    input  logic [NUM_CS*SPAN_W-1:0] cfg_span,
    input  logic [NUM_CS*2-1:0]      cfg_port,
    input  logic [NUM_CS*2-1:0]      cfg_dead,
    input  logic [NUM_CS*2-1:0]      cfg_hold,
    input  logic [NUM_CS-1:0]        cfg_burst,
    output logic [NUM_CS-1:0]        ext_cs,
    output logic [ADDR_W-1:0]        ext_addr,
    output logic [1:0]               ext_tsiz,
    output logic                     ext_rd,
    output logic                     ext_wr,
    output logic                     ext_burst,
    output logic [DATA_W-1:0]        ext_wdata,
    input  logic [DATA_W-1:0]        ext_rdata
);

    localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

    cs_cfg_t          cfg_arr [NUM_CS];
    cs_cfg_t          sel_cfg;
    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    logic [2:0]       plan_bytes, plan_count;
    logic [1:0]       plan_tsiz;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_cfg
        assign cfg_arr[g] = {cfg_port[2*g +: 2], cfg_dead[2*g +: 2],
                             cfg_hold[2*g +: 2], cfg_burst[g]};
    end

    assign sel_cfg = cfg_arr[dec_idx];

    csbus_decode #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .SPAN_W (SPAN_W),
        .IDX_W  (IDX_W)
    ) decode_i (
        .addr     (req_addr),
        .cfg_base (cfg_base),
        .cfg_span (cfg_span),
        .hit      (dec_hit),
        .sel_idx  (dec_idx)
    );

    csbus_plan plan_i (
        .size_code  (req_size),
        .port_code  (sel_cfg.port),
        .beat_bytes (plan_bytes),
        .beat_count (plan_count),
        .beat_tsiz  (plan_tsiz)
    );

    csbus_seq #(
        .NUM_CS (NUM_CS),
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) seq_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .req_write  (req_write),
        .req_wdata  (req_wdata),
        .dec_hit    (dec_hit),
        .dec_idx    (dec_idx),
        .sel_dead   (sel_cfg.dead),
        .sel_hold   (sel_cfg.hold),
        .sel_burst  (sel_cfg.burst),
        .plan_bytes (plan_bytes),
        .plan_count (plan_count),
        .plan_tsiz  (plan_tsiz),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .rsp_err    (rsp_err),
        .ext_cs     (ext_cs),
        .ext_addr   (ext_addr),
        .ext_tsiz   (ext_tsiz),
        .ext_rd     (ext_rd),
        .ext_wr     (ext_wr),
        .ext_burst  (ext_burst),
        .ext_wdata  (ext_wdata),
        .ext_rdata  (ext_rdata)
    );

endmodule

// File: rtl/csbus_chk.sv
module csbus_chk #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [NUM_CS-1:0] ext_cs,
    input logic              ext_rd,
    input logic              ext_wr,
    input logic [1:0]        ext_tsiz,
    input logic              ext_burst,
    input logic [ADDR_W-1:0] ext_addr
);

    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(ext_cs)); // R2
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst) !(ext_rd && ext_wr)); // R12
    AST_STROBE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst) (ext_rd || ext_wr) |-> (|ext_cs)); // R12
    AST_CS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst) (|ext_cs) |-> (ext_rd || ext_wr)); // R12
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) rsp_done |=> !rsp_done); // R11
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) (|ext_cs) |-> !req_ready); // R11
    AST_DONE_NOT_READY: assert property (@(posedge clk) disable iff (rst) rsp_done |-> !req_ready); // R11
    AST_NO_CS_AT_DONE: assert property (@(posedge clk) disable iff (rst) rsp_done |-> (ext_cs == '0)); // R9
    AST_TSIZ_LEGAL: assert property (@(posedge clk) disable iff (rst) (|ext_cs) |-> (ext_tsiz != 2'b11)); // R7
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst) rsp_err |-> rsp_done); // R3
    AST_BURST_HAS_CS: assert property (@(posedge clk) disable iff (rst) ext_burst |-> (|ext_cs)); // R8
    AST_BURST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst) (ext_burst && $past(ext_burst)) |-> (ext_addr != $past(ext_addr))); // R5

endmodule

bind csbus_ctrl csbus_chk #(
    .NUM_CS (NUM_CS),
    .ADDR_W (ADDR_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_err   (rsp_err),
    .ext_cs    (ext_cs),
    .ext_rd    (ext_rd),
    .ext_wr    (ext_wr),
    .ext_tsiz  (ext_tsiz),
    .ext_burst (ext_burst),
    .ext_addr  (ext_addr)
);

// File: tb/csbus_ctrl_tb_top.sv
`timescale 1ns/1ps
module csbus_ctrl_tb_top;

    localparam int NCS = 4;
    localparam int AW  = 32;
    localparam int SW  = 5;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst;
    logic            req_valid, req_ready, req_write;
    logic [AW-1:0]   req_addr;
    logic [1:0]      req_size;
    logic [31:0]     req_wdata;
    logic            rsp_done, rsp_err;
    logic [31:0]     rsp_rdata;
    logic [NCS*AW-1:0] cfg_base;
    logic [NCS*SW-1:0] cfg_span;
    logic [NCS*2-1:0]  cfg_port, cfg_dead, cfg_hold;
    logic [NCS-1:0]    cfg_burst;
    logic [NCS-1:0]    ext_cs;
    logic [AW-1:0]     ext_addr;
    logic [1:0]        ext_tsiz;
    logic              ext_rd, ext_wr, ext_burst;
    logic [31:0]       ext_wdata, ext_rdata;

    csbus_ctrl #(.NUM_CS(NCS), .ADDR_W(AW), .SPAN_W(SW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .cfg_base(cfg_base), .cfg_span(cfg_span), .cfg_port(cfg_port),
        .cfg_dead(cfg_dead), .cfg_hold(cfg_hold), .cfg_burst(cfg_burst),
        .ext_cs(ext_cs), .ext_addr(ext_addr), .ext_tsiz(ext_tsiz),
        .ext_rd(ext_rd), .ext_wr(ext_wr), .ext_burst(ext_burst),
        .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
    );

    // region table of the bench; regions 0 and 3 overlap
    logic [31:0] tb_base  [NCS] = '{32'h1000_0000, 32'h2000_0000, 32'h3000_0000, 32'h1000_0000};
    int          tb_span  [NCS] = '{16, 12, 20, 24};
    int          tb_port  [NCS] = '{0, 1, 2, 1};
    int          tb_dead  [NCS] = '{2, 0, 3, 1};
    int          tb_hold  [NCS] = '{1, 3, 0, 2};
    int          tb_burst [NCS] = '{1, 0, 0, 1};

    function automatic logic [7:0] dev_byte(input logic [31:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    assign ext_rdata = {dev_byte(ext_addr + 32'd3), dev_byte(ext_addr + 32'd2),
                        dev_byte(ext_addr + 32'd1), dev_byte(ext_addr)};

    typedef struct {
        int          cs;
        logic [31:0] addr;
        logic [1:0]  tsiz;
        logic        we;
        logic [31:0] wdata;
        logic        burst;
    } beat_t;

    typedef struct {
        logic [31:0] rdata;
        logic        err;
    } resp_t;

    beat_t beat_q[$];
    resp_t resp_q[$];

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_tag  = "R1";
    int    cyc      = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            check(1'b0, "watchdog", "run did not finish", 32'(cyc), 32'd100000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    // monitor: compares external beats and responses against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (|ext_cs) begin
                if (beat_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected chip select", 32'(ext_cs), 32'd0);
                end else begin
                    beat_t e;
                    e = beat_q.pop_front();
                    check(ext_cs == NCS'(1 << e.cs), "R2", "chip select", 32'(ext_cs), 32'(1 << e.cs));
                    check(ext_addr == e.addr, "R5", "beat address", ext_addr, e.addr);
                    check(ext_tsiz == e.tsiz, "R7", "tsiz", 32'(ext_tsiz), 32'(e.tsiz));
                    check(ext_wr == e.we && ext_rd == !e.we, "R12", "strobes",
                          {30'd0, ext_rd, ext_wr}, {30'd0, !e.we, e.we});
                    check(ext_wdata == e.wdata, "R5", "write lanes", ext_wdata, e.wdata);
                    check(ext_burst == e.burst, "R8", "burst marker", 32'(ext_burst), 32'(e.burst));
                end
            end
            if (rsp_done) begin
                if (resp_q.size() == 0) begin
                    check(1'b0, cur_tag, "unexpected done", 32'd1, 32'd0);
                end else begin
                    resp_t r;
                    r = resp_q.pop_front();
                    check(rsp_rdata == r.rdata, "R6", {"read data ", cur_tag}, rsp_rdata, r.rdata);
                    check(rsp_err == r.err, "R3", {"error flag ", cur_tag}, 32'(rsp_err), 32'(r.err));
                end
            end
        end
    end

    task automatic do_req(input logic [31:0] addr, input int szc, input bit we,
                          input logic [31:0] wd, input string tag);
        int          hit = -1;
        int          szb, pb, bb, nb, lat_exp, lat;
        logic [31:0] rd_exp = '0;
        logic [31:0] mask;
        cur_tag = tag;
        for (int i = 0; i < NCS; i++) begin
            if (hit < 0 && ((addr ^ tb_base[i]) >> tb_span[i]) == 0) hit = i;
        end
        szb = 1 << szc;
        if (hit < 0) begin
            lat_exp = 1;
            resp_q.push_back('{32'd0, 1'b1});
        end else begin
            pb   = 1 << tb_port[hit];
            bb   = (szb < pb) ? szb : pb;
            nb   = szb / bb;
            mask = (bb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * bb)) - 32'd1);
            for (int b = 0; b < nb; b++) begin
                beat_t e;
                e.cs    = hit;
                e.addr  = addr + 32'(b * bb);
                e.tsiz  = (bb == 1) ? 2'b01 : (bb == 2) ? 2'b10 : 2'b00;
                e.we    = we;
                e.wdata = we ? ((wd >> (8 * b * bb)) & mask) : 32'd0;
                e.burst = (tb_burst[hit] != 0) && (nb > 1);
                beat_q.push_back(e);
            end
            if (!we) begin
                for (int k = 0; k < szb; k++) rd_exp |= 32'(dev_byte(addr + 32'(k))) << (8 * k);
            end
            lat_exp = nb + ((tb_burst[hit] != 0) ? 0 : nb - 1)
                    + (we ? tb_hold[hit] : tb_dead[hit]) + 1;
            resp_q.push_back('{rd_exp, 1'b0});
        end
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr  = addr;
        req_size  = 2'(szc);
        req_write = we;
        req_wdata = wd;
        req_valid = 1'b1;
        @(posedge clk);
        #1 req_valid = 1'b0;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
            if (lat == 1) check(!req_ready, "R11", "ready low while busy", 32'(req_ready), 32'd0);
        end while (!rsp_done && lat < 50);
        check(lat == lat_exp, (we ? "R10" : "R9"), {"latency ", tag}, 32'(lat), 32'(lat_exp));
        @(negedge clk);
        check(req_ready && !rsp_done, "R11", "ready after done pulse",
              {30'd0, req_ready, rsp_done}, 32'd2);
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_addr = '0; req_size = '0; req_write = 1'b0; req_wdata = '0;
        for (int i = 0; i < NCS; i++) begin
            cfg_base[i*AW +: AW] = tb_base[i];
            cfg_span[i*SW +: SW] = SW'(tb_span[i]);
            cfg_port[i*2 +: 2]   = 2'(tb_port[i]);
            cfg_dead[i*2 +: 2]   = 2'(tb_dead[i]);
            cfg_hold[i*2 +: 2]   = 2'(tb_hold[i]);
            cfg_burst[i]         = tb_burst[i][0];
        end
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(req_ready && !rsp_done && !rsp_err, "R1", "response side idle",
              {29'd0, req_ready, rsp_done, rsp_err}, 32'd4);
        check(ext_cs == '0 && !ext_rd && !ext_wr, "R1", "bus idle",
              {26'd0, ext_cs, ext_rd, ext_wr}, 32'd0);

        do_req(32'h3000_0010, 2, 1'b0, 32'd0,        "R9");  // 32-bit port, 3 dead cycles
        do_req(32'h3000_0020, 2, 1'b1, 32'hDEAD_BEEF, "R10"); // no hold cycles
        do_req(32'h1000_8000, 2, 1'b0, 32'd0,        "R2");  // overlap, region 0 wins, 4 burst beats
        do_req(32'h1000_0102, 1, 1'b1, 32'hAABB_1234, "R5");  // two byte beats, lane order
        do_req(32'h2000_0040, 2, 1'b1, 32'h8765_4321, "R8");  // non-burst gap, 3 hold cycles
        do_req(32'h2000_0041, 0, 1'b0, 32'd0,        "R7");  // single byte on 16-bit port
        do_req(32'h1010_0000, 2, 1'b0, 32'd0,        "R4");  // region 3, two burst beats
        do_req(32'h1010_0006, 1, 1'b0, 32'd0,        "R7");  // one 2-byte beat, no burst marker
        do_req(32'h5000_0000, 2, 1'b0, 32'd0,        "R3");  // unmapped read
        do_req(32'h5000_0004, 2, 1'b1, 32'h1111_2222, "R3");  // unmapped write
        do_req(32'h2000_0080, 2, 1'b0, 32'd0,        "R6");  // non-burst read assembly
        do_req(32'h1000_0203, 0, 1'b1, 32'h0000_00C3, "R12"); // byte write on 8-bit port

        repeat (3) @(negedge clk);
        check(beat_q.size() == 0, "R4", "all expected beats seen", 32'(beat_q.size()), 32'd0);
        check(resp_q.size() == 0, "R11", "all responses seen", 32'(resp_q.size()), 32'd0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule